// File: doc/BRIEF.md
# Counter Snapshot SPI Slave

The block keeps a free-running event counter in its reference clock domain and hands a copy of it to an SPI host on request. When the host pulls chip select low, the current count is frozen into a transmit word. The count sits in the upper bits of that word and a fixed marker nibble of all ones sits in the low four bits. The host then clocks the word out in SPI mode 0, most significant bit first.

The SPI pins are not used as clocks. Chip select and the serial clock are brought into the reference domain through multi-flop synchronizers, and their edges are detected there. The frame is therefore loaded from the counter in the same clock domain that owns it. Because of this, no counter bit is ever sampled while it is changing, and the snapshot cannot tear. The serial output comes straight from the top flop of a loadable left-shifting register rather than from a wide bit-index multiplexer. The reference clock must run several times faster than the serial clock.

Top module: `ctr_snap_spi`

## Requirements
- R1: After reset release the counter advances by exactly one on every rising reference clock edge, so a frame's counter field lies within a few cycles of the number of reference edges counted since reset release at the moment chip select fell.
- R2: Driving rst_n low clears the counter asynchronously and holds spi_miso low; after release the counter restarts from zero.
- R3: The frame is 64 bits: bits 63:4 carry the counter value and bits 3:0 always read 4'b1111.
- R4: Mode 0 with MSB first: the host reads bit 63 before its first rising SCLK edge, and each falling SCLK edge while selected moves the next lower bit onto spi_miso, ending with bit 0.
- R5: The frame is frozen when chip select falls; the counter's continued counting does not change the word during the transfer.
- R6: While spi_cs_n is high, spi_miso is driven low and SCLK edges have no effect on the next frame, which still starts at bit 63.
- R7: Raising spi_cs_n in the middle of a frame abandons it; the next selection delivers a fresh complete frame starting at bit 63.
- R8: Frames read at arbitrary intervals without an intervening reset never show a smaller counter field than the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the counter and all logic run on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI serial clock from the host, idles low |
| spi_cs_n | input | 1 | SPI chip select from the host, active low |
| spi_miso | output | 1 | Serial data to the host, low while not selected |

## Verification
The hardest case to reach from the pins is proving that the word is frozen at the select edge and not later. The count climbs by more than a thousand during one frame, so the bench records the number of reference edges when it drops chip select. It then requires the received counter field to fall in a narrow window around that number, which a late or rolling capture would miss. The same window check, together with the fixed marker nibble, exposes any bit-order or starting-position error after idle SCLK toggling or an aborted frame, because a shifted or reversed word cannot land in the window.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int unsigned SNAP_CNT_W  = 60;
  localparam int unsigned SNAP_TAG_W  = 4;
  localparam int unsigned SNAP_SYNC_N = 2;
endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], d_i[b]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
        else        chain_q <= chain_d;
      end
      assign q_o[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/snap_counter.sv
module snap_counter #(
  parameter int unsigned CNT_W = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  always_comb count_d = count_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/snap_shifter.sv
module snap_shifter #(
  parameter int unsigned FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_idle_i,
  input  logic               sclk_s_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sclk_fall_o,
  output logic [FRAME_W-1:0] shift_o,
  output logic               miso_o
);
  logic               sclk_prev_q;
  logic [FRAME_W-1:0] shift_q;
  logic [FRAME_W-1:0] shift_d;
  logic               shift_en;
  logic               sclk_fall;

  always_comb begin
    sclk_fall = sclk_prev_q & ~sclk_s_i;
    shift_en  = cs_idle_i | sclk_fall;
    if (cs_idle_i) shift_d = frame_i;
    else           shift_d = {shift_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  assign sclk_fall_o = sclk_fall;
  assign shift_o     = shift_q;
  assign miso_o      = shift_q[FRAME_W-1] & ~cs_idle_i;
endmodule

// File: rtl/ctr_snap_spi.sv
module ctr_snap_spi
  import snap_pkg::*;
#(
  parameter int unsigned CNT_W  = SNAP_CNT_W,
  parameter int unsigned TAG_W  = SNAP_TAG_W,
  parameter int unsigned SYNC_N = SNAP_SYNC_N,
  parameter logic [TAG_W-1:0] TAG = '1
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  output logic spi_miso
);
  localparam int unsigned FRAME_W = CNT_W + TAG_W;

  logic               core_rst_n;
  logic [1:0]         pins_s;
  logic               cs_idle;
  logic               sclk_s;
  logic               sclk_fall;
  logic [CNT_W-1:0]   cnt_value;
  logic [FRAME_W-1:0] frame_word;
  logic [FRAME_W-1:0] shift_value;

  snap_sync #(.WIDTH(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) rst_sync_i (
    .clk(clk_ref), .rst_n(rst_n), .d_i(1'b1), .q_o(core_rst_n)
  );

  snap_sync #(.WIDTH(2), .STAGES(SYNC_N), .RST_VAL(2'b10)) pin_sync_i (
    .clk(clk_ref), .rst_n(core_rst_n), .d_i({spi_cs_n, spi_sclk}), .q_o(pins_s)
  );

  assign cs_idle = pins_s[1];
  assign sclk_s  = pins_s[0];

  snap_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk_ref), .rst_n(core_rst_n), .count_o(cnt_value)
  );

  assign frame_word = {cnt_value, TAG};

  snap_shifter #(.FRAME_W(FRAME_W)) shifter_i (
    .clk(clk_ref), .rst_n(core_rst_n), .cs_idle_i(cs_idle), .sclk_s_i(sclk_s),
    .frame_i(frame_word), .sclk_fall_o(sclk_fall), .shift_o(shift_value),
    .miso_o(spi_miso)
  );
endmodule

// File: rtl/ctr_snap_spi_chk.sv
module ctr_snap_spi_chk #(
  parameter int unsigned CNT_W   = 60,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned FRAME_W = 64,
  parameter logic [TAG_W-1:0] TAG = '1
) (
  input logic               clk,
  input logic               core_rst_n,
  input logic [CNT_W-1:0]   count_q,
  input logic [FRAME_W-1:0] shift_q,
  input logic               cs_idle,
  input logic               sclk_fall,
  input logic               spi_miso
);
  // R1: one step per reference edge
  p_count_step_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> count_q == $past(count_q) + 1'b1);

  // R6: output held low while deselected
  p_miso_idle_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    cs_idle |-> !spi_miso);

  // R3: marker nibble present when the frame freezes
  p_tag_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(cs_idle) |-> shift_q[TAG_W-1:0] == TAG);

  // R5: frozen word changes only on a falling serial clock
  p_frozen_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cs_idle && !sclk_fall) |=> $stable(shift_q));

  // R4: falling serial clock moves the word left by one
  p_shift_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cs_idle && sclk_fall) |=>
      (shift_q[FRAME_W-1:1] == $past(shift_q[FRAME_W-2:0])) && !shift_q[0]);
endmodule

bind ctr_snap_spi ctr_snap_spi_chk #(
  .CNT_W(CNT_W), .TAG_W(TAG_W), .FRAME_W(FRAME_W), .TAG(TAG)
) chk_i (
  .clk(clk_ref), .core_rst_n(core_rst_n), .count_q(cnt_value),
  .shift_q(shift_value), .cs_idle(cs_idle), .sclk_fall(sclk_fall),
  .spi_miso(spi_miso)
);

// File: tb/ctr_snap_spi_tb_top.sv
module ctr_snap_spi_tb_top;
  localparam int HALF = 10;

  logic clk_ref = 1'b0;
  logic rst_n;
  logic spi_sclk;
  logic spi_cs_n;
  logic spi_miso;

  int checks = 0;
  int errors = 0;
  logic [63:0] cyc;
  logic [59:0] last_cnt;
  int watchdog = 0;
  bit  done = 0;

  always #2 clk_ref = ~clk_ref;

  ctr_snap_spi dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  always @(posedge clk_ref or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 64'd1;

  always @(posedge clk_ref) begin
    watchdog <= watchdog + 1;
    if (watchdog > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", watchdog, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic spi_read(output logic [63:0] w, output logic [63:0] n, input int nbits);
    w = '0;
    @(negedge clk_ref);
    spi_cs_n = 1'b0;
    n = cyc;
    idle(HALF);
    for (int i = 63; i >= 64 - nbits; i--) begin
      w[i] = spi_miso;
      spi_sclk = 1'b1;
      idle(HALF);
      spi_sclk = 1'b0;
      idle(HALF);
    end
    spi_cs_n = 1'b1;
    idle(HALF);
  endtask

  // R1 R3 R5 R8 verdicts on one frame
  task automatic judge(input logic [63:0] w, input logic [63:0] n, input string tag);
    logic [63:0] f;
    f = {4'h0, w[63:4]};
    chk(w[3:0] == 4'hF, {"R3 ", tag}, {60'd0, w[3:0]}, 64'hF);
    chk(f + 64'd4 >= n && f <= n + 64'd2, {"R1 R5 ", tag}, f, n - 64'd1);
    chk(w[63:4] >= last_cnt, {"R8 ", tag}, f, {4'h0, last_cnt});
    last_cnt = w[63:4];
  endtask

  task automatic t_reset;
    rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1;
    idle(5);
    chk(spi_miso == 1'b0, "R2 miso in reset", {63'd0, spi_miso}, 64'd0);
    rst_n = 1'b1;
    idle(8);
    chk(spi_miso == 1'b0, "R6 miso idle after reset", {63'd0, spi_miso}, 64'd0);
    last_cnt = '0;
  endtask

  task automatic t_first;
    logic [63:0] w, n;
    spi_read(w, n, 64);
    judge(w, n, "first frame");
  endtask

  task automatic t_random_reads;
    logic [63:0] w, n;
    for (int k = 0; k < 6; k++) begin
      idle(1 + ($urandom % 3000));
      spi_read(w, n, 64);
      judge(w, n, "random gap R4");
    end
  endtask

  task automatic t_idle_sclk;
    logic [63:0] w, n;
    bit low = 1;
    for (int k = 0; k < 20; k++) begin
      spi_sclk = 1'b1; idle(HALF);
      low &= (spi_miso == 1'b0);
      spi_sclk = 1'b0; idle(HALF);
      low &= (spi_miso == 1'b0);
    end
    chk(low, "R6 miso low with sclk while deselected", {63'd0, !low}, 64'd0);
    spi_read(w, n, 64);
    judge(w, n, "after idle sclk R6");
  endtask

  task automatic t_abort;
    logic [63:0] w, n;
    spi_read(w, n, 10);
    chk(w[63:54] == 10'd0, "R7 partial frame top bits", {54'd0, w[63:54]}, 64'd0);
    spi_read(w, n, 64);
    judge(w, n, "after abort R7");
  endtask

  task automatic t_mid_reset;
    logic [63:0] w, n;
    idle(500);
    @(negedge clk_ref);
    rst_n = 1'b0;
    idle(2);
    chk(spi_miso == 1'b0, "R2 miso during second reset", {63'd0, spi_miso}, 64'd0);
    rst_n = 1'b1;
    last_cnt = '0;
    idle(40);
    spi_read(w, n, 64);
    chk(w[63:4] < 60'd100, "R2 counter restarted", {4'h0, w[63:4]}, n - 64'd1);
    judge(w, n, "after second reset");
  endtask

  initial begin
    t_reset;
    t_first;
    t_random_reads;
    t_idle_sclk;
    t_abort;
    t_random_reads;
    t_mid_reset;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule